// File: doc/BRIEF.md
# Word-FIFO to Byte-Stream Data Engine

This block sits between a host-side queue of 32-bit words and a byte-wide card data port. The host first loads a transfer length, then writes a control word that starts the engine and picks a direction. In the card-to-host direction the engine collects one card byte per cycle, packs bytes into words in little-endian lane order and queues each word for the host. A final partial word is queued with its upper lanes zero. In the host-to-card direction it takes queued words and sends them out one byte per cycle, lowest lane first. When the byte count runs out, any bytes left in the current word are dropped.

A remaining-byte counter tracks progress, and a word-count view reports it rounded up to whole words. Two sticky end markers flag completion. Two five-bit flag groups describe the queue fill level, and only the group that matches the current direction is ever non-zero. When the count is zero and the queue is empty, the engine turns itself off.

Top module: `wbe_top`

## Requirements
- R1: After reset, engEnable, remaining, wordCount, txFlags, rxFlags, xferEnd, blockEnd, popErr, cardTake and cardOutValid are all zero.
- R2: A ctrlWe cycle with ctrlWdata[0]=1 loads remaining from the 16-bit length register (written via lenWe) and sets engEnable. ctrlWdata[1]=1 selects card-to-host, 0 selects host-to-card. ctrlWdata[0]=0 clears engEnable. wordCount always equals (remaining+3)/4, rounded down.
- R3: In card-to-host mode a byte is taken (cardTake=1) on every cycle in which remaining is non-zero, cardRdy is 1 and the queue holds fewer than 16 words. The first byte of each word lands in bits [7:0] and later bytes in successively higher lanes.
- R4: When remaining runs out in the middle of a word, that word is queued with its unfilled upper lanes zero.
- R5: In host-to-card mode a new word is taken from the queue only after the previous word's bytes are used up. Bytes leave on cardOutByte lowest lane first, one per cardOutValid cycle, and sending stops when remaining reaches zero, even if bytes of the current word are left.
- R6: remaining falls by exactly one for each byte taken or sent.
- R7: The cycle after remaining is zero while engEnable is 1, xferEnd and blockEnd are both 1. They stay 1 until the next start.
- R8: While remaining is zero and the queue is empty, engEnable clears itself on the next edge. Both flag groups read zero in that state.
- R9: Flag encoding while active: bit4 active, bit3 half level (TX: fill ≤ 8; RX: fill ≥ 8), bit2 full (fill = 16), bit1 empty (fill = 0), bit0 data available (fill > 0).
- R10: rxFlags is non-zero only in card-to-host mode, and txFlags only in host-to-card mode.
- R11: With 16 words queued, card-to-host intake stalls (cardTake=0, remaining held). A host push while the queue is full is ignored.
- R12: A host pop (hostPop) on an empty queue outside host-to-card mode returns hostRdata=0 and sets popErr, which stays set until reset. A host pop on a non-empty queue returns the oldest word in the same cycle.
- R13: The queue is circular over 16 slots, and word order is preserved across the wrap of its positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lenWe | input | 1 | Load the length register |
| lenWdata | input | 16 | Transfer length in bytes |
| ctrlWe | input | 1 | Write the control word |
| ctrlWdata | input | 2 | Bit0 start, bit1 card-to-host direction |
| hostPush | input | 1 | Host queues a word (host-to-card mode) |
| hostWdata | input | 32 | Word queued by the host |
| hostPop | input | 1 | Host takes a word |
| hostRdata | output | 32 | Word returned to the host this cycle |
| cardRdy | input | 1 | Card has a byte available |
| cardInByte | input | 8 | Byte from the card |
| cardTake | output | 1 | Card byte consumed at this edge |
| cardOutValid | output | 1 | cardOutByte is sent at this edge |
| cardOutByte | output | 8 | Byte to the card |
| engEnable | output | 1 | Engine running |
| dirRead | output | 1 | Current direction, 1 = card-to-host |
| remaining | output | 16 | Bytes left in the transfer |
| wordCount | output | 16 | Remaining bytes rounded up to words |
| xferEnd | output | 1 | Sticky end-of-data marker |
| blockEnd | output | 1 | Sticky end-of-block marker |
| txFlags | output | 5 | Host-to-card queue flags |
| rxFlags | output | 5 | Card-to-host queue flags |
| popErr | output | 1 | Sticky pop-from-empty marker |

## Verification
A wrong queue fill count shows on the flag groups in the same cycle: data-available, empty, full and the half-level bit all derive from it. A stale fill also shows when the engine turns itself off too early or never. A wrong lane pointer or shift register is seen on the next queued word or the next sent byte, since each byte is placed or chosen by that state. A counter that steps wrongly moves remaining and wordCount at once. It also moves the end markers one cycle later, so every error in the byte path surfaces within one word of the fault.

// File: rtl/wbe_pkg.sv
package wbe_pkg;
  // per-cycle strobes from control to datapath
  typedef struct packed {
    logic load;      // start: reload counter, clear packers
    logic takeByte;  // card byte accepted
    logic sendByte;  // byte sent to card
    logic engPush;   // packed word into queue
    logic engPop;    // word out of queue into unpacker
    logic hostPush;  // host word into queue
    logic hostPop;   // host takes head word
  } strobe_t;
endpackage

// File: rtl/wbe_datapath.sv
module wbe_datapath
  import wbe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic                          lenWe,
  input  logic [LEN_W-1:0]              lenWdata,
  input  logic [WORD_W-1:0]             hostWdata,
  input  logic [7:0]                    cardInByte,
  output logic [LEN_W-1:0]              remaining,
  output logic [$clog2(DEPTH+1)-1:0]    fill,
  output logic [$clog2(WORD_W/8)-1:0]   lane,
  output logic [$clog2(WORD_W/8)-1:0]   bytesLeft,
  output logic [WORD_W-1:0]             head,
  output logic [7:0]                    cardOutByte
);
  localparam int LANES  = WORD_W / 8;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LANE_W = $clog2(LANES);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPos;
  logic [PTR_W-1:0]  wrIdx;
  logic [LEN_W-1:0]  lenReg;
  logic [WORD_W-1:0] packReg;
  logic [WORD_W-1:0] packWord;
  logic [WORD_W-1:0] shReg;
  logic [WORD_W-1:0] pushData;
  logic              doPush;
  logic              doPop;

  assign doPush   = stb.engPush | stb.hostPush;
  assign doPop    = stb.engPop | stb.hostPop;
  assign wrIdx    = rdPos + PTR_W'(fill);
  assign head     = mem[rdPos];
  assign packWord = packReg | (WORD_W'(cardInByte) << {lane, 3'b000});
  assign pushData = stb.engPush ? packWord : hostWdata;
  assign cardOutByte = (bytesLeft == '0) ? head[7:0] : shReg[7:0];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrIdx] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenReg    <= '0;
      remaining <= '0;
      fill      <= '0;
      rdPos     <= '0;
      lane      <= '0;
      packReg   <= '0;
      bytesLeft <= '0;
      shReg     <= '0;
    end else begin
      if (lenWe) lenReg <= lenWdata;
      fill <= fill + CNT_W'(doPush) - CNT_W'(doPop);
      if (doPop) rdPos <= rdPos + 1'b1;
      if (stb.load) begin
        remaining <= lenReg;
        lane      <= '0;
        packReg   <= '0;
        bytesLeft <= '0;
        shReg     <= '0;
      end else begin
        if (stb.takeByte || stb.sendByte) remaining <= remaining - 1'b1;
        if (stb.takeByte) begin
          if (stb.engPush) begin
            lane    <= '0;
            packReg <= '0;
          end else begin
            lane    <= lane + 1'b1;
            packReg <= packWord;
          end
        end
        if (stb.sendByte) begin
          if (remaining == LEN_W'(1)) begin
            bytesLeft <= '0;  // tail bytes dropped
          end else if (stb.engPop) begin
            shReg     <= head >> 8;
            bytesLeft <= LANE_W'(LANES - 1);
          end else begin
            shReg     <= shReg >> 8;
            bytesLeft <= bytesLeft - 1'b1;
          end
        end
      end
    end
  end

  a_r11_no_push_full: assert property (@(posedge clk) disable iff (!rstN)
    (fill == CNT_W'(DEPTH)) |-> !doPush);
  a_r13_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fill <= CNT_W'(DEPTH));
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.takeByte || stb.sendByte) && !stb.load) |=> remaining == $past(remaining) - 1'b1);
  a_r12_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    (fill == '0) |-> !doPop);
endmodule

// File: rtl/wbe_control.sv
module wbe_control
  import wbe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          ctrlWe,
  input  logic [1:0]                    ctrlWdata,
  input  logic                          cardRdy,
  input  logic                          hostPushReq,
  input  logic                          hostPopReq,
  input  logic [LEN_W-1:0]              remaining,
  input  logic [$clog2(DEPTH+1)-1:0]    fill,
  input  logic [$clog2(WORD_W/8)-1:0]   lane,
  input  logic [$clog2(WORD_W/8)-1:0]   bytesLeft,
  output strobe_t                       stb,
  output logic                          engEnable,
  output logic                          dirRead,
  output logic                          xferEnd,
  output logic                          popErr,
  output logic [4:0]                    txFlags,
  output logic [4:0]                    rxFlags
);
  localparam int LANES = WORD_W / 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF  = DEPTH / 2;

  logic rdMode, wrMode, notFull, notEmpty, remZero, live;
  logic [4:0] txBase, rxBase;

  assign rdMode   = engEnable & dirRead;
  assign wrMode   = engEnable & ~dirRead;
  assign notFull  = fill < CNT_W'(DEPTH);
  assign notEmpty = fill != '0;
  assign remZero  = remaining == '0;
  assign live     = engEnable & ~(remZero & ~notEmpty);

  always_comb begin
    stb          = '0;
    stb.load     = ctrlWe & ctrlWdata[0];
    stb.takeByte = rdMode & ~remZero & notFull & cardRdy;
    stb.engPush  = stb.takeByte &
                   ((lane == $bits(lane)'(LANES - 1)) | (remaining == LEN_W'(1)));
    stb.sendByte = wrMode & ~remZero & ((bytesLeft != '0) | notEmpty);
    stb.engPop   = stb.sendByte & (bytesLeft == '0);
    stb.hostPush = hostPushReq & wrMode & ~remZero & notFull;
    stb.hostPop  = hostPopReq & ~wrMode & notEmpty;
  end

  assign txBase = {1'b1, fill <= CNT_W'(HALF), fill == CNT_W'(DEPTH), ~notEmpty, notEmpty};
  assign rxBase = {1'b1, fill >= CNT_W'(HALF), fill == CNT_W'(DEPTH), ~notEmpty, notEmpty};
  assign txFlags = (live & ~dirRead) ? txBase : 5'b0;
  assign rxFlags = (live &  dirRead) ? rxBase : 5'b0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engEnable <= 1'b0;
      dirRead   <= 1'b0;
      xferEnd   <= 1'b0;
      popErr    <= 1'b0;
    end else begin
      if (ctrlWe) begin
        engEnable <= ctrlWdata[0];
        dirRead   <= ctrlWdata[1];
      end else if (engEnable && remZero && !notEmpty) begin
        engEnable <= 1'b0;
      end
      if (stb.load) xferEnd <= 1'b0;
      else if (engEnable && remZero) xferEnd <= 1'b1;
      if (hostPopReq && !wrMode && !notEmpty) popErr <= 1'b1;
    end
  end

  a_r8_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    (engEnable && remZero && !notEmpty && !ctrlWe) |=> !engEnable);
  a_r7_end_mark: assert property (@(posedge clk) disable iff (!rstN)
    (engEnable && remZero && !ctrlWe) |=> xferEnd);
  a_r10_one_group: assert property (@(posedge clk) disable iff (!rstN)
    !((|txFlags) && (|rxFlags)));
  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    popErr |=> popErr);
endmodule

// File: rtl/wbe_top.sv
module wbe_top
  import wbe_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lenWe,
  input  logic [LEN_W-1:0]  lenWdata,
  input  logic              ctrlWe,
  input  logic [1:0]        ctrlWdata,
  input  logic              hostPush,
  input  logic [WORD_W-1:0] hostWdata,
  input  logic              hostPop,
  output logic [WORD_W-1:0] hostRdata,
  input  logic              cardRdy,
  input  logic [7:0]        cardInByte,
  output logic              cardTake,
  output logic              cardOutValid,
  output logic [7:0]        cardOutByte,
  output logic              engEnable,
  output logic              dirRead,
  output logic [LEN_W-1:0]  remaining,
  output logic [LEN_W-1:0]  wordCount,
  output logic              xferEnd,
  output logic              blockEnd,
  output logic [4:0]        txFlags,
  output logic [4:0]        rxFlags,
  output logic              popErr
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LANE_W = $clog2(WORD_W / 8);

  strobe_t            stb;
  logic [CNT_W-1:0]   fill;
  logic [LANE_W-1:0]  lane;
  logic [LANE_W-1:0]  bytesLeft;
  logic [WORD_W-1:0]  head;
  logic [LEN_W:0]     remPlus;

  wbe_control #(.DEPTH(DEPTH), .WORD_W(WORD_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .cardRdy(cardRdy), .hostPushReq(hostPush), .hostPopReq(hostPop),
    .remaining(remaining), .fill(fill), .lane(lane), .bytesLeft(bytesLeft),
    .stb(stb), .engEnable(engEnable), .dirRead(dirRead), .xferEnd(xferEnd),
    .popErr(popErr), .txFlags(txFlags), .rxFlags(rxFlags)
  );

  wbe_datapath #(.DEPTH(DEPTH), .WORD_W(WORD_W), .LEN_W(LEN_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .lenWe(lenWe), .lenWdata(lenWdata),
    .hostWdata(hostWdata), .cardInByte(cardInByte), .remaining(remaining),
    .fill(fill), .lane(lane), .bytesLeft(bytesLeft), .head(head),
    .cardOutByte(cardOutByte)
  );

  assign remPlus      = {1'b0, remaining} + (LEN_W+1)'(3);
  assign wordCount    = LEN_W'(remPlus >> 2);
  assign hostRdata    = stb.hostPop ? head : '0;
  assign cardTake     = stb.takeByte;
  assign cardOutValid = stb.sendByte;
  assign blockEnd     = xferEnd;
endmodule

// File: tb/tb_wbe_top.sv
module tb_wbe_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] len;
    logic [7:0]  seed;
    logic [7:0]  words;
    logic [31:0] first;
    logic [31:0] last;
  } vec_t;

  localparam vec_t [0:3] VECS = '{
    '{len: 16'd4, seed: 8'h10, words: 8'd1, first: 32'h13121110, last: 32'h13121110},
    '{len: 16'd6, seed: 8'hA0, words: 8'd2, first: 32'hA3A2A1A0, last: 32'h0000A5A4},
    '{len: 16'd9, seed: 8'h01, words: 8'd3, first: 32'h04030201, last: 32'h00000009},
    '{len: 16'd1, seed: 8'hFF, words: 8'd1, first: 32'h000000FF, last: 32'h000000FF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lenWe = 1'b0;
  logic [15:0] lenWdata = '0;
  logic ctrlWe = 1'b0;
  logic [1:0] ctrlWdata = '0;
  logic hostPush = 1'b0;
  logic [31:0] hostWdata = '0;
  logic hostPop = 1'b0;
  logic [31:0] hostRdata;
  logic cardRdy = 1'b0;
  logic [7:0] cardInByte;
  logic cardTake, cardOutValid;
  logic [7:0] cardOutByte;
  logic engEnable, dirRead, xferEnd, blockEnd, popErr;
  logic [15:0] remaining, wordCount;
  logic [4:0] txFlags, rxFlags;

  logic [7:0]  curSeed = '0;
  logic [15:0] curLen = '0;
  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  // card byte source: seed plus index of the byte within the transfer
  assign cardInByte = curSeed + 8'(curLen - remaining);

  always #(CLK_PERIOD/2) clk = ~clk;

  wbe_top dut (
    .clk(clk), .rstN(rstN), .lenWe(lenWe), .lenWdata(lenWdata),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .hostPush(hostPush),
    .hostWdata(hostWdata), .hostPop(hostPop), .hostRdata(hostRdata),
    .cardRdy(cardRdy), .cardInByte(cardInByte), .cardTake(cardTake),
    .cardOutValid(cardOutValid), .cardOutByte(cardOutByte),
    .engEnable(engEnable), .dirRead(dirRead), .remaining(remaining),
    .wordCount(wordCount), .xferEnd(xferEnd), .blockEnd(blockEnd),
    .txFlags(txFlags), .rxFlags(rxFlags), .popErr(popErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setLen(input logic [15:0] l);
    @(negedge clk); lenWe = 1'b1; lenWdata = l;
    @(negedge clk); lenWe = 1'b0;
  endtask

  // start; returns at the negedge just after the start edge
  task automatic startXfer(input logic rd, input logic [15:0] l, input logic [7:0] sd);
    curLen = l; curSeed = sd;
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = {rd, 1'b1};
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic popWord(output logic [31:0] w);
    @(negedge clk); hostPop = 1'b1;
    #1 w = hostRdata;
    @(posedge clk);
    #1 hostPop = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [7:0] got [0:11];
    int nGot;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 engEnable", engEnable, 0);
    chk("R1 remaining", remaining, 0);
    chk("R1 wordCount", wordCount, 0);
    chk("R1 flags", {txFlags, rxFlags}, 0);
    chk("R1 end/err", {xferEnd, blockEnd, popErr, cardTake, cardOutValid}, 0);

    // R12 pop from empty queue
    @(negedge clk); hostPop = 1'b1;
    #1 chk("R12 empty pop data", hostRdata, 0);
    @(negedge clk); hostPop = 1'b0;
    chk("R12 popErr set", popErr, 1);

    // table of card-to-host transfers
    for (int v = 0; v < 4; v++) begin
      setLen(VECS[v].len);
      startXfer(1'b1, VECS[v].len, VECS[v].seed);
      chk("R2 remaining loaded", remaining, VECS[v].len);
      chk("R2 wordCount", wordCount, VECS[v].words);
      chk("R2 dirRead/enable", {dirRead, engEnable}, 2'b11);
      chk("R9 R10 rx flags at start", {txFlags, rxFlags}, {5'b0, 5'b10010});
      chk("R7 end cleared by start", xferEnd, 0);
      cardRdy = 1'b1;
      repeat (VECS[v].len + 2) @(negedge clk);
      cardRdy = 1'b0;
      chk("R6 remaining drained", remaining, 0);
      chk("R7 end markers", {xferEnd, blockEnd}, 2'b11);
      for (int k = 0; k < VECS[v].words; k++) begin
        chk("R9 data available before pop", rxFlags[0], 1);
        popWord(w);
        if (k == 0) chk("R3 first word lanes", w, VECS[v].first);
        if (k == VECS[v].words - 1) chk("R4 last word", w, VECS[v].last);
      end
      @(negedge clk);
      @(negedge clk);
      chk("R8 self clear", engEnable, 0);
      chk("R8 flags zero", {txFlags, rxFlags}, 0);
    end

    // zero length start
    setLen(16'd0);
    startXfer(1'b1, 16'd0, 8'h00);
    chk("R8 zero-length flags", {txFlags, rxFlags}, 0);
    @(negedge clk);
    chk("R7 zero-length end", xferEnd, 1);
    chk("R8 zero-length clear", engEnable, 0);

    // full queue stall and wrap: 72 bytes = 18 words
    setLen(16'd72);
    startXfer(1'b1, 16'd72, 8'h00);
    cardRdy = 1'b1;
    repeat (80) @(negedge clk);
    chk("R11 stalled remaining", remaining, 8);
    chk("R11 no take when full", cardTake, 0);
    chk("R9 full rx flags", rxFlags, 5'b11101);
    chk("R2 wordCount at 8", wordCount, 2);
    for (int k = 0; k < 18; k++) begin
      for (int t = 0; t < 20 && !rxFlags[0]; t++) @(negedge clk);
      popWord(w);
      chk("R13 order across wrap", w,
          {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    end
    cardRdy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 clear after wrap", engEnable, 0);

    // host-to-card: 6 bytes from 3 queued words
    setLen(16'd6);
    startXfer(1'b0, 16'd6, 8'h00);
    chk("R10 tx flags at start", {txFlags, rxFlags}, {5'b11010, 5'b0});
    nGot = 0;
    for (int i = 0; i < 12; i++) begin
      if (i != 0) @(negedge clk);
      if (cardOutValid && nGot < 12) begin
        got[nGot] = cardOutByte;
        nGot++;
      end
      hostPush  = (i < 3);
      hostWdata = (i == 0) ? 32'h44332211 : (i == 1) ? 32'h88776655 : 32'hCCBBAA99;
    end
    hostPush = 1'b0;
    @(negedge clk);
    chk("R5 byte count sent", nGot, 6);
    for (int b = 0; b < 6; b++)
      chk("R5 byte order", got[b], 8'(8'h11 * (b + 1)));
    chk("R6 remaining zero", remaining, 0);
    chk("R9 R10 tx flags with leftover word", {txFlags, rxFlags}, {5'b11001, 5'b0});
    chk("R7 write end", xferEnd, 1);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = 2'b00;
    @(negedge clk); ctrlWe = 1'b0;
    chk("R2 stop clears enable", {engEnable, txFlags}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule